// File: doc/BRIEF.md
# Fetch-Stage Recent-Instruction Buffer

This block sits beside the instruction fetch stage and keeps a small, fully associative window of the last `DEPTH` instructions the stage has fetched, each stored with the address it came from. Every sequential fetch is written in as it happens. When a branch redirects fetch, the target address is probed against all stored addresses in the same cycle. If a valid entry matches, the instruction is handed back at once and memory is left alone. If nothing matches, the block requests the target from memory. When the instruction returns, it is captured as a new entry.

Slots are reused in strict arrival order, so the window always holds the most recent arrivals. A flush input discards the whole window in one cycle. All writes happening in the same cycle as a probe are visible to that probe, so a target fetched one moment earlier is never sent to memory again.

Top module: `fetch_loop_buf`

## Requirements
- R1: After reset no entry is valid and no miss is outstanding, so every redirect misses until something is written.
- R2: When `fill_valid` is high and no flush occurs, the pair (`fill_addr`, `fill_insn`) is stored and is found by a redirect from the next cycle on.
- R3: A redirect whose target equals the address of a valid entry drives `hit_valid`=1 and `hit_insn` with that entry's instruction in the same cycle, with `mem_req`=0.
- R4: A redirect that finds no match drives `mem_req`=1 and `mem_addr` equal to the target in the same cycle, with `hit_valid`=0. The target becomes the outstanding miss, replacing any earlier outstanding miss.
- R5: There are `DEPTH` slots, written in circular order. Once all slots are valid, each new write replaces the oldest entry.
- R6: `mem_rsp_valid` while a miss is outstanding stores (outstanding target, `mem_rsp_insn`) as the newest entry and clears the outstanding miss. `mem_rsp_valid` with no miss outstanding is ignored.
- R7: If a memory response and a fill arrive in the same cycle, only the response is stored and the fill is dropped.
- R8: A redirect in the same cycle as a write to the same address hits and returns the instruction being written.
- R9: When several valid entries share the target address, the most recently written one supplies `hit_insn`.
- R10: `flush` clears every entry at the next edge. Any write in the flush cycle is discarded, and a redirect in the flush cycle misses.
- R11: `hit_valid` and `mem_req` are never high together, and both stay low while `redir_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate the whole window |
| fill_valid | input | 1 | A sequential fetch is being recorded |
| fill_addr | input | FLB_ADDR_W | Address of the recorded fetch |
| fill_insn | input | FLB_INSN_W | Instruction of the recorded fetch |
| redir_valid | input | 1 | Branch redirect probe this cycle |
| redir_addr | input | FLB_ADDR_W | Branch target address |
| hit_valid | output | 1 | Target found; instruction supplied |
| hit_insn | output | FLB_INSN_W | Instruction for the target on a hit |
| mem_req | output | 1 | Target missing; fetch it from memory |
| mem_addr | output | FLB_ADDR_W | Address of the memory request |
| mem_rsp_valid | input | 1 | Memory returns the requested instruction |
| mem_rsp_insn | input | FLB_INSN_W | Instruction returned by memory |

## Verification
The cases that need care are the ones where a probe and a write share a cycle. A redirect can arrive in the same cycle as a fill or a memory response for the same address. A fill can also collide with a memory response, or with a flush. The bench drives each pair in one cycle and checks the combinational hit outputs before the edge. It then probes the same address on later cycles to confirm which write, if any, was kept. A repeated address written twice with different instructions is probed afterwards to confirm that the newer copy wins.

// File: rtl/flb_pkg.sv
package flb_pkg;

    parameter int unsigned FLB_ADDR_W = 32;
    parameter int unsigned FLB_INSN_W = 32;

    typedef logic [FLB_ADDR_W-1:0] flb_addr_t;
    typedef logic [FLB_INSN_W-1:0] flb_insn_t;

    // One slot of the window, also used as the write bundle.
    typedef struct packed {
        logic      valid;
        flb_addr_t addr;
        flb_insn_t insn;
    } flb_entry_t;

    // Which source owns the single write port this cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FILL = 2'd1,
        SRC_MISS = 2'd2
    } flb_src_e;

    // Slot index written 'steps' writes before the slot at 'ptr'.
    function automatic int unsigned ring_back(int unsigned ptr,
                                              int unsigned steps,
                                              int unsigned depth);
        return (ptr + depth - steps) % depth;
    endfunction

endpackage

// File: rtl/flb_insert_sel.sv
module flb_insert_sel
    import flb_pkg::*;
(
    input  logic       flush,
    input  logic       fill_valid,
    input  flb_addr_t  fill_addr,
    input  flb_insn_t  fill_insn,
    input  logic       rsp_valid,
    input  flb_insn_t  rsp_insn,
    input  logic       pend_valid,
    input  flb_addr_t  pend_addr,
    output flb_entry_t wr,
    output flb_src_e   src
);

    // Memory response outranks a sequential fill; flush suppresses both.
    always_comb begin
        wr  = '0;
        src = SRC_NONE;
        if (!flush) begin
            if (rsp_valid && pend_valid) begin
                wr.valid = 1'b1;
                wr.addr  = pend_addr;
                wr.insn  = rsp_insn;
                src      = SRC_MISS;
            end else if (fill_valid) begin
                wr.valid = 1'b1;
                wr.addr  = fill_addr;
                wr.insn  = fill_insn;
                src      = SRC_FILL;
            end
        end
    end

endmodule

// File: rtl/flb_store.sv
module flb_store
    import flb_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  flb_entry_t       wr,
    output flb_entry_t       ent_q [DEPTH],
    output logic [PTR_W-1:0] wr_ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    // Circular write pointer: the slot after the newest entry is the oldest.
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
        end else if (wr.valid) begin
            wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (flush) begin
                ent_q[g].valid <= 1'b0;
            end else if (wr.valid && (wr_ptr == PTR_W'(g))) begin
                ent_q[g] <= wr;
            end
        end
    end

endmodule

// File: rtl/flb_match.sv
module flb_match
    import flb_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  flb_entry_t       ent_q [DEPTH],
    input  logic [PTR_W-1:0] wr_ptr,
    input  flb_entry_t       wr,
    input  logic             flush,
    input  logic             probe_valid,
    input  flb_addr_t        probe_addr,
    output logic             hit,
    output flb_insn_t        hit_insn
);

    logic [DEPTH-1:0] tag_hit;
    logic             bypass;
    logic             found;
    flb_insn_t        found_insn;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign tag_hit[g] = ent_q[g].valid && (ent_q[g].addr == probe_addr);
    end

    // Same-cycle write is the newest copy of its address.
    assign bypass = wr.valid && (wr.addr == probe_addr);

    // Walk from the newest slot backwards; first match wins.
    always_comb begin
        int unsigned idx;
        found      = 1'b0;
        found_insn = '0;
        for (int unsigned k = 1; k <= DEPTH; k++) begin
            idx = ring_back(int'(wr_ptr), k, DEPTH);
            if (!found && tag_hit[idx]) begin
                found      = 1'b1;
                found_insn = ent_q[idx].insn;
            end
        end
    end

    assign hit      = probe_valid && !flush && (bypass || found);
    assign hit_insn = bypass ? wr.insn : found_insn;

endmodule

// File: rtl/flb_miss_track.sv
module flb_miss_track
    import flb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      miss,
    input  flb_addr_t miss_addr,
    input  flb_src_e  src,
    output logic      pend_valid,
    output flb_addr_t pend_addr
);

    // A new miss replaces the outstanding one; a consumed response clears it.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
        end else if (miss) begin
            pend_valid <= 1'b1;
            pend_addr  <= miss_addr;
        end else if (src == SRC_MISS) begin
            pend_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/fetch_loop_buf.sv
module fetch_loop_buf
    import flb_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic                  fill_valid,
    input  logic [FLB_ADDR_W-1:0] fill_addr,
    input  logic [FLB_INSN_W-1:0] fill_insn,
    input  logic                  redir_valid,
    input  logic [FLB_ADDR_W-1:0] redir_addr,
    output logic                  hit_valid,
    output logic [FLB_INSN_W-1:0] hit_insn,
    output logic                  mem_req,
    output logic [FLB_ADDR_W-1:0] mem_addr,
    input  logic                  mem_rsp_valid,
    input  logic [FLB_INSN_W-1:0] mem_rsp_insn
);

    flb_entry_t       wr;
    flb_src_e         src;
    flb_entry_t       ent_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic             pend_valid;
    flb_addr_t        pend_addr;
    logic             hit;
    logic             miss;

    flb_insert_sel u_sel (
        .flush      (flush),
        .fill_valid (fill_valid),
        .fill_addr  (fill_addr),
        .fill_insn  (fill_insn),
        .rsp_valid  (mem_rsp_valid),
        .rsp_insn   (mem_rsp_insn),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr),
        .wr         (wr),
        .src        (src)
    );

    flb_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .wr     (wr),
        .ent_q  (ent_q),
        .wr_ptr (wr_ptr)
    );

    flb_match #(.DEPTH(DEPTH)) u_match (
        .ent_q       (ent_q),
        .wr_ptr      (wr_ptr),
        .wr          (wr),
        .flush       (flush),
        .probe_valid (redir_valid),
        .probe_addr  (redir_addr),
        .hit         (hit),
        .hit_insn    (hit_insn)
    );

    assign miss = redir_valid && !hit;

    flb_miss_track u_miss (
        .clk        (clk),
        .rst        (rst),
        .miss       (miss),
        .miss_addr  (redir_addr),
        .src        (src),
        .pend_valid (pend_valid),
        .pend_addr  (pend_addr)
    );

    assign hit_valid = hit;
    assign mem_req   = miss;
    assign mem_addr  = redir_addr;

endmodule

// File: rtl/flb_checker.sv
module flb_checker (
    input logic clk,
    input logic rst,
    input logic flush,
    input logic fill_valid,
    input logic mem_rsp_valid,
    input logic redir_valid,
    input logic hit_valid,
    input logic mem_req
);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(hit_valid && mem_req));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !redir_valid |-> (!hit_valid && !mem_req));

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && redir_valid && !fill_valid && !mem_rsp_valid) |-> !hit_valid);

    a_r10_empty_after_flush: assert property (@(posedge clk) disable iff (rst)
        ($past(flush) && redir_valid && !fill_valid && !mem_rsp_valid) |-> mem_req);

    a_r10_flush_cycle_miss: assert property (@(posedge clk) disable iff (rst)
        (flush && redir_valid) |-> (mem_req && !hit_valid));

endmodule

bind fetch_loop_buf flb_checker u_flb_checker (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .fill_valid    (fill_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .redir_valid   (redir_valid),
    .hit_valid     (hit_valid),
    .mem_req       (mem_req)
);

// File: tb/tb_fetch_loop_buf.sv
module tb_fetch_loop_buf;
    import flb_pkg::*;

    localparam int unsigned DEPTH = 4;
    localparam int unsigned NVEC  = 24;

    logic      clk = 1'b0;
    logic      rst, flush, fill_valid, redir_valid, mem_rsp_valid;
    flb_addr_t fill_addr, redir_addr, mem_addr;
    flb_insn_t fill_insn, hit_insn, mem_rsp_insn;
    logic      hit_valid, mem_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fetch_loop_buf #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .flush(flush),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_insn(fill_insn),
        .redir_valid(redir_valid), .redir_addr(redir_addr),
        .hit_valid(hit_valid), .hit_insn(hit_insn),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_insn(mem_rsp_insn)
    );

    typedef struct packed {
        logic        fv;  logic [15:0] fa; logic [15:0] fi;
        logic        rv;  logic [15:0] ra;
        logic        mv;  logic [15:0] mi;
        logic        fl;
        logic        eh;  logic [15:0] ei; logic er;
        logic [3:0]  rq;
    } vec_t;

    // fv fa fi | rv ra | mv mi | fl | exp_hit exp_insn exp_req | req
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,16'h0010,16'hA001, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 1'b0,16'h0000,1'b0, 4'd11}, // R11 idle
        '{1'b1,16'h0014,16'hA002, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 1'b0,16'h0000,1'b0, 4'd2},  // R2
        '{1'b1,16'h0018,16'hA003, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 1'b0,16'h0000,1'b0, 4'd2},  // R2
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h0014, 1'b0,16'h0000, 1'b0, 1'b1,16'hA002,1'b0, 4'd3},  // R3
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h0040, 1'b0,16'h0000, 1'b0, 1'b0,16'h0000,1'b1, 4'd4},  // R4
        '{1'b0,16'h0000,16'h0000, 1'b0,16'h0000, 1'b1,16'hA040, 1'b0, 1'b0,16'h0000,1'b0, 4'd6},  // R6
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h0040, 1'b0,16'h0000, 1'b0, 1'b1,16'hA040,1'b0, 4'd6},  // R6
        '{1'b1,16'h001C,16'hA004, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 1'b0,16'h0000,1'b0, 4'd5},  // R5
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h0010, 1'b0,16'h0000, 1'b0, 1'b0,16'h0000,1'b1, 4'd5},  // R5
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h0018, 1'b0,16'h0000, 1'b0, 1'b1,16'hA003,1'b0, 4'd3},  // R3
        '{1'b1,16'h0020,16'hB001, 1'b1,16'h0020, 1'b0,16'h0000, 1'b0, 1'b1,16'hB001,1'b0, 4'd8},  // R8
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h0014, 1'b0,16'h0000, 1'b0, 1'b0,16'h0000,1'b1, 4'd5},  // R5
        '{1'b1,16'h0024,16'hB002, 1'b0,16'h0000, 1'b1,16'hC014, 1'b0, 1'b0,16'h0000,1'b0, 4'd7},  // R7
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h0024, 1'b0,16'h0000, 1'b0, 1'b0,16'h0000,1'b1, 4'd7},  // R7
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h0014, 1'b0,16'h0000, 1'b0, 1'b1,16'hC014,1'b0, 4'd7},  // R7
        '{1'b1,16'h0014,16'hD014, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0, 1'b0,16'h0000,1'b0, 4'd9},  // R9
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h0014, 1'b0,16'h0000, 1'b0, 1'b1,16'hD014,1'b0, 4'd9},  // R9
        '{1'b1,16'h0030,16'hE030, 1'b1,16'h0014, 1'b0,16'h0000, 1'b1, 1'b0,16'h0000,1'b1, 4'd10}, // R10
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h0030, 1'b0,16'h0000, 1'b0, 1'b0,16'h0000,1'b1, 4'd10}, // R10
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h001C, 1'b0,16'h0000, 1'b0, 1'b0,16'h0000,1'b1, 4'd10}, // R10
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h001C, 1'b1,16'hF01C, 1'b0, 1'b1,16'hF01C,1'b0, 4'd8},  // R8
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h001C, 1'b0,16'h0000, 1'b0, 1'b1,16'hF01C,1'b0, 4'd6},  // R6
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h001C, 1'b1,16'h6666, 1'b0, 1'b1,16'hF01C,1'b0, 4'd6},  // R6
        '{1'b0,16'h0000,16'h0000, 1'b1,16'h001C, 1'b0,16'h0000, 1'b0, 1'b1,16'hF01C,1'b0, 4'd6}   // R6
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input int rq, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flush = 1'b0; fill_valid = 1'b0; fill_addr = '0; fill_insn = '0;
        redir_valid = 1'b0; redir_addr = '0;
        mem_rsp_valid = 1'b0; mem_rsp_insn = '0;
    endtask

    // Inputs set after a falling edge, outputs judged 5 ns later, then clocked.
    task automatic probe(input logic [31:0] a, input logic eh,
                         input logic [31:0] ei, input int rq);
        redir_valid = 1'b1; redir_addr = a;
        #5;
        check({31'd0, hit_valid}, {31'd0, eh}, rq, "hit_valid");
        check({31'd0, mem_req}, {31'd0, !eh}, rq, "mem_req");
        if (eh) check(hit_insn, ei, rq, "hit_insn");
        else    check(mem_addr, a, rq, "mem_addr");
        @(posedge clk); @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        idle_inputs();
        rst = 1'b1; fill_valid = 1'b1; fill_addr = 32'h0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; idle_inputs();
    endtask

    initial begin
        do_reset();

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            fill_valid    = VECS[v].fv; fill_addr = 32'(VECS[v].fa); fill_insn = 32'(VECS[v].fi);
            redir_valid   = VECS[v].rv; redir_addr = 32'(VECS[v].ra);
            mem_rsp_valid = VECS[v].mv; mem_rsp_insn = 32'(VECS[v].mi);
            flush         = VECS[v].fl;
            #5;
            check({31'd0, hit_valid}, {31'd0, VECS[v].eh}, int'(VECS[v].rq), "hit_valid");
            check({31'd0, mem_req}, {31'd0, VECS[v].er}, int'(VECS[v].rq), "mem_req");
            if (VECS[v].eh) check(hit_insn, 32'(VECS[v].ei), int'(VECS[v].rq), "hit_insn");
            if (VECS[v].er) check(mem_addr, 32'(VECS[v].ra), int'(VECS[v].rq), "mem_addr");
            @(posedge clk); @(negedge clk);
            idle_inputs();
        end

        // R1: reset empties the window and drops the outstanding miss
        do_reset();
        #5;
        check({31'd0, hit_valid}, 32'd0, 1, "hit_valid idle after reset");
        check({31'd0, mem_req}, 32'd0, 1, "mem_req idle after reset");
        @(negedge clk);
        // R6: response with nothing outstanding must not create an entry
        mem_rsp_valid = 1'b1; mem_rsp_insn = 32'h99;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        probe(32'h0, 1'b0, 32'h0, 6);
        probe(32'h1C, 1'b0, 32'h0, 1);
        probe(32'h14, 1'b0, 32'h0, 1);

        // R5: five fills into four slots, the first one is gone
        for (int k = 0; k < 5; k++) begin
            fill_valid = 1'b1; fill_addr = 32'h100 + 32'(4 * k); fill_insn = 32'h5000 + 32'(k);
            @(posedge clk); @(negedge clk);
        end
        idle_inputs();
        probe(32'h100, 1'b0, 32'h0, 5);
        for (int k = 1; k < 5; k++) begin
            probe(32'h100 + 32'(4 * k), 1'b1, 32'h5000 + 32'(k), 5); // R2 R5
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule